// File: doc/BRIEF.md
# ECC Read-Merge-Write Memory Datapath

This block sits between a requester and a memory whose words hold two 64-bit quadwords, each stored beside its own 8-bit single-error-correcting, double-error-detecting check code. A full write is encoded on the way in, one code per quadword, and stored directly. A write that covers only some bytes of a quadword becomes a read-merge-write sequence. The block reads the stored word, repairs a single-bit error if it can, merges in the enabled bytes, encodes the result again and writes it back.

Reads are checked against the stored codes. In correcting mode the repaired data is returned one cycle after the memory answers. In detect-only mode the raw data is returned in the same cycle as the memory answers and errors are only reported. With ECC switched off, codes are neither written nor checked and partial writes go straight to memory under their byte mask. Correctable and uncorrectable events each produce a one-cycle pulse and advance a saturating counter, and the address of the last uncorrectable event is held for the requester.

Top module: `ecc_rmw_datapath`

## Requirements
- R1: A write whose lanes each have a byte mask of 0x00 or 0xFF issues one memory write with no memory read. Memory word byte j (bits j*8+7..j*8) is enabled by mem_wbe[j]. Lane l uses bytes l*9..l*9+7 for data and byte l*9+8 for its code. A later read returns the written data without any error event.
- R2: In correcting mode (mode 2, and also 3), a single flipped bit in a lane's data or code is repaired in the read response and counts as one correctable event.
- R3: Two flipped bits in one lane are reported as an uncorrectable event. That lane's data is returned unmodified, and err_addr takes the request address.
- R4: With checking on (mode 1, 2 or 3), a write in which some lane has a mask other than 0x00 or 0xFF performs exactly one memory read and then one memory write. In correcting mode, a single-bit error in the bytes that are kept is repaired before the merge.
- R5: If the read phase of a read-merge-write finds an uncorrectable error, the write is still completed, an uncorrectable event is reported, and err_addr holds the write address.
- R6: In detect-only mode (mode 1), errors are reported but never corrected. The response is valid in the same cycle as mem_rvalid, while in correcting mode it follows one cycle later.
- R7: With ECC off (mode 0), a partial write issues no memory read and leaves the code byte unwritten (only that lane's data byte enables are set). A read with ECC off returns raw data and raises no error event.
- R8: A lane with mask 0x00 is left unchanged by any write. A lane with mask 0xFF never causes a read phase.
- R9: req_ready is low from the cycle after a read or a read-merge-write is accepted until that sequence completes. After a direct write it is high again in the next cycle.
- R10: err_ce_pulse and err_ue_pulse are single-cycle pulses, registered one cycle after the memory data that caused them. Each pulse raises its counter by one, up to its all-ones limit, and the counters change at no other time. All of these are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 ECC off, 1 detect only, 2 or 3 correct; sampled with each request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_wdata | input | 128 | Write data, lane 0 in the low quadword |
| req_be | input | 16 | Byte enables, lane 0 in the low byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 128 | Read response data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 144 | Memory write word, per lane {code, data} |
| mem_wbe | output | 18 | Memory byte write enables |
| mem_rvalid | input | 1 | Memory read data valid (fixed latency) |
| mem_rdata | input | 144 | Memory read word |
| err_ce_pulse | output | 1 | Correctable event pulse |
| err_ue_pulse | output | 1 | Uncorrectable event pulse |
| err_addr | output | AW | Address of last uncorrectable event |
| ce_count | output | CNT_W | Saturating correctable-event counter |
| ue_count | output | CNT_W | Saturating uncorrectable-event counter |

## Verification
The two lanes are decoded side by side, so a correctable error in one lane and an uncorrectable error in the other fall into the same read response. The bench provokes this by flipping one bit of lane 0 and two bits of lane 1 in the memory model, then reading that word in correcting mode. It judges the outcome by requiring both pulses in one cycle, lane 0 repaired, lane 1 returned raw, both counters advanced and err_addr updated. The counter width is reduced in the bench so that later correctable events run into the saturation limit.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    localparam int QW_BITS      = 64;
    localparam int CODE_BITS    = 8;
    localparam int BYTES_PER_QW = QW_BITS / 8;
    localparam int HAM_BITS     = CODE_BITS - 1;
    localparam int LAST_POS     = QW_BITS + HAM_BITS;
    localparam logic [HAM_BITS-1:0] LAST_POS_S = HAM_BITS'(LAST_POS);

    typedef logic [QW_BITS-1:0]   qword_t;
    typedef logic [CODE_BITS-1:0] code_t;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_DETECT  = 2'd1,
        MODE_CORRECT = 2'd2,
        MODE_RSVD    = 2'd3
    } ecc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MERGE = 2'd2
    } seq_state_e;

    typedef struct packed {
        qword_t data;
        logic   ce;
        logic   ue;
    } dec_res_t;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // XOR of the Hamming positions of all set data bits
    function automatic logic [HAM_BITS-1:0] ham_syn(qword_t d);
        logic [HAM_BITS-1:0] s;
        qword_t t;
        s = '0;
        t = d;
        for (int p = 1; p <= LAST_POS; p++) begin
            if (!is_pow2(p)) begin
                if (t[0]) s = s ^ p[HAM_BITS-1:0];
                t = t >> 1;
            end
        end
        return s;
    endfunction

    // flip the data bit that sits at Hamming position pos
    function automatic qword_t flip_at(qword_t d, logic [HAM_BITS-1:0] pos);
        qword_t m;
        qword_t r;
        m = qword_t'(1);
        r = d;
        for (int p = 1; p <= LAST_POS; p++) begin
            if (!is_pow2(p)) begin
                if (p[HAM_BITS-1:0] == pos) r = r ^ m;
                m = m << 1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc
    import ecc_rmw_pkg::*;
(
    input  qword_t data_i,
    output code_t  code_o
);
    logic [HAM_BITS-1:0] syn;

    always_comb begin
        syn    = ham_syn(data_i);
        code_o = {^{data_i, syn}, syn};
    end
endmodule

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec
    import ecc_rmw_pkg::*;
(
    input  qword_t   data_i,
    input  code_t    code_i,
    output dec_res_t res_o
);
    logic [HAM_BITS-1:0] syn;
    logic                odd;

    always_comb begin
        syn        = ham_syn(data_i) ^ code_i[HAM_BITS-1:0];
        odd        = ^{data_i, code_i};
        res_o.data = data_i;
        res_o.ce   = 1'b0;
        res_o.ue   = 1'b0;
        if (odd) begin
            if (syn <= LAST_POS_S) begin
                res_o.ce   = 1'b1;
                res_o.data = flip_at(data_i, syn);
            end else begin
                res_o.ue = 1'b1;
            end
        end else if (syn != '0) begin
            res_o.ue = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_err_stats.sv
module ecc_err_stats #(
    parameter int AW    = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_ev_i,
    input  logic             ue_ev_i,
    input  logic [AW-1:0]    addr_i,
    output logic             ce_pulse_o,
    output logic             ue_pulse_o,
    output logic [AW-1:0]    ue_addr_o,
    output logic [CNT_W-1:0] ce_cnt_o,
    output logic [CNT_W-1:0] ue_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_pulse_o <= 1'b0;
            ue_pulse_o <= 1'b0;
            ue_addr_o  <= '0;
            ce_cnt_o   <= '0;
            ue_cnt_o   <= '0;
        end else begin
            ce_pulse_o <= ce_ev_i;
            ue_pulse_o <= ue_ev_i;
            if (ce_ev_i && ce_cnt_o != CNT_MAX) ce_cnt_o <= ce_cnt_o + 1'b1;
            if (ue_ev_i && ue_cnt_o != CNT_MAX) ue_cnt_o <= ue_cnt_o + 1'b1;
            if (ue_ev_i) ue_addr_o <= addr_i;
        end
    end
endmodule

// File: rtl/ecc_rmw_datapath.sv
module ecc_rmw_datapath
    import ecc_rmw_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LANES = 2,
    parameter int CNT_W = 8,
    localparam int LW   = QW_BITS + CODE_BITS,
    localparam int DW   = LANES * QW_BITS,
    localparam int MW   = LANES * LW,
    localparam int BW   = LANES * BYTES_PER_QW,
    localparam int EW   = LANES * (BYTES_PER_QW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [BW-1:0]    req_be,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_addr,
    output logic [MW-1:0]    mem_wdata,
    output logic [EW-1:0]    mem_wbe,
    input  logic             mem_rvalid,
    input  logic [MW-1:0]    mem_rdata,
    output logic             err_ce_pulse,
    output logic             err_ue_pulse,
    output logic [AW-1:0]    err_addr,
    output logic [CNT_W-1:0] ce_count,
    output logic [CNT_W-1:0] ue_count
);
    localparam int LBE = BYTES_PER_QW + 1;

    seq_state_e        state;
    ecc_mode_e         mode_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [BW-1:0]     be_q;
    logic              rd_q, wr_q, rsp_q;
    logic [MW-1:0]     wword_q;
    logic [EW-1:0]     wbe_q;
    logic [DW-1:0]     rsp_data_q;

    logic              correcting, checking, needs_rmw, ev_valid;
    logic [LANES-1:0]  lane_partial, lane_ce, lane_ue;
    logic [DW-1:0]     corr_data, raw_data;
    logic [MW-1:0]     direct_word, rmw_word;
    logic [EW-1:0]     direct_wbe, rmw_wbe;

    assign correcting = (mode_q == MODE_CORRECT) || (mode_q == MODE_RSVD);
    assign checking   = (mode_q != MODE_OFF);
    assign needs_rmw  = (mode != MODE_OFF) && (|lane_partial);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        qword_t raw_d, base_d, merged_d;
        code_t  raw_c, merged_c, direct_c;
        dec_res_t dres;
        logic [BYTES_PER_QW-1:0] be_in, be_st;

        assign be_in = req_be[l*BYTES_PER_QW +: BYTES_PER_QW];
        assign be_st = be_q[l*BYTES_PER_QW +: BYTES_PER_QW];
        assign raw_d = mem_rdata[l*LW +: QW_BITS];
        assign raw_c = mem_rdata[l*LW + QW_BITS +: CODE_BITS];

        ecc_lane_dec u_dec (.data_i(raw_d), .code_i(raw_c), .res_o(dres));

        assign base_d = correcting ? dres.data : raw_d;
        for (genvar b = 0; b < BYTES_PER_QW; b++) begin : g_byte
            assign merged_d[b*8 +: 8] = be_st[b] ? wdata_q[l*QW_BITS + b*8 +: 8]
                                                 : base_d[b*8 +: 8];
        end

        ecc_lane_enc u_menc (.data_i(merged_d), .code_o(merged_c));
        ecc_lane_enc u_denc (.data_i(req_wdata[l*QW_BITS +: QW_BITS]), .code_o(direct_c));

        assign lane_partial[l] = (be_in != '0) && (be_in != '1);
        assign lane_ce[l]      = dres.ce;
        assign lane_ue[l]      = dres.ue;
        assign corr_data[l*QW_BITS +: QW_BITS] = dres.data;
        assign raw_data[l*QW_BITS +: QW_BITS]  = raw_d;

        assign direct_word[l*LW +: LW] = {direct_c, req_wdata[l*QW_BITS +: QW_BITS]};
        assign direct_wbe[l*LBE +: LBE] = (mode == MODE_OFF) ? {1'b0, be_in} : {LBE{|be_in}};
        assign rmw_word[l*LW +: LW]    = {merged_c, merged_d};
        assign rmw_wbe[l*LBE +: LBE]   = {LBE{|be_st}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mode_q     <= MODE_OFF;
            addr_q     <= '0;
            wdata_q    <= '0;
            be_q       <= '0;
            rd_q       <= 1'b0;
            wr_q       <= 1'b0;
            rsp_q      <= 1'b0;
            wword_q    <= '0;
            wbe_q      <= '0;
            rsp_data_q <= '0;
        end else begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            rsp_q <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    mode_q  <= ecc_mode_e'(mode);
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    be_q    <= req_be;
                    if (!req_write) begin
                        rd_q  <= 1'b1;
                        state <= ST_READ;
                    end else if (needs_rmw) begin
                        rd_q  <= 1'b1;
                        state <= ST_MERGE;
                    end else begin
                        wr_q    <= 1'b1;
                        wword_q <= direct_word;
                        wbe_q   <= direct_wbe;
                    end
                end
                ST_READ: if (mem_rvalid) begin
                    state <= ST_IDLE;
                    if (correcting) begin
                        rsp_q      <= 1'b1;
                        rsp_data_q <= corr_data;
                    end
                end
                ST_MERGE: if (mem_rvalid) begin
                    wr_q    <= 1'b1;
                    wword_q <= rmw_word;
                    wbe_q   <= rmw_wbe;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_rd_en = rd_q;
    assign mem_wr_en = wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wword_q;
    assign mem_wbe   = wbe_q;

    assign rsp_valid = rsp_q | ((state == ST_READ) && mem_rvalid && !correcting);
    assign rsp_rdata = rsp_q ? rsp_data_q : raw_data;

    assign ev_valid = (state != ST_IDLE) && mem_rvalid && checking;

    ecc_err_stats #(.AW(AW), .CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst        (rst),
        .ce_ev_i    (ev_valid && (|lane_ce)),
        .ue_ev_i    (ev_valid && (|lane_ue)),
        .addr_i     (addr_q),
        .ce_pulse_o (err_ce_pulse),
        .ue_pulse_o (err_ue_pulse),
        .ue_addr_o  (err_addr),
        .ce_cnt_o   (ce_count),
        .ue_cnt_o   (ue_count)
    );
endmodule

// File: rtl/ecc_rmw_chk.sv
module ecc_rmw_chk #(
    parameter int AW    = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic             mem_rvalid,
    input logic             err_ce_pulse,
    input logic             err_ue_pulse,
    input logic [AW-1:0]    err_addr,
    input logic [CNT_W-1:0] ce_count,
    input logic [CNT_W-1:0] ue_count,
    input logic [AW-1:0]    addr_q
);
    // R9
    rd_stall_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !req_ready);

    // R9
    wait_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !mem_rvalid) |=> !req_ready);

    // R1
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    // R10
    ce_step_chk: assert property (@(posedge clk) disable iff (rst)
        err_ce_pulse |-> ((ce_count == $past(ce_count) + 1'b1) || ($past(ce_count) == '1)));

    // R10
    ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_ce_pulse |-> $stable(ce_count));

    // R10
    ue_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_ue_pulse |-> $stable(ue_count));

    // R5
    ue_addr_chk: assert property (@(posedge clk) disable iff (rst)
        err_ue_pulse |-> (err_addr == $past(addr_q)));
endmodule

bind ecc_rmw_datapath ecc_rmw_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .mem_rvalid   (mem_rvalid),
    .err_ce_pulse (err_ce_pulse),
    .err_ue_pulse (err_ue_pulse),
    .err_addr     (err_addr),
    .ce_count     (ce_count),
    .ue_count     (ue_count),
    .addr_q       (addr_q)
);

// File: tb/tb_ecc_rmw_datapath.sv
module tb_ecc_rmw_datapath;
    localparam int AW    = 4;
    localparam int CNT_W = 2;
    localparam int DW    = 128;
    localparam int MW    = 144;
    localparam int BW    = 16;
    localparam int EW    = 18;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0]       mode = 2'd2;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic [BW-1:0]    req_be = '0;
    logic             req_ready, rsp_valid, mem_rd_en, mem_wr_en, mem_rvalid;
    logic [DW-1:0]    rsp_rdata;
    logic [AW-1:0]    mem_addr, err_addr;
    logic [MW-1:0]    mem_wdata, mem_rdata;
    logic [EW-1:0]    mem_wbe;
    logic             err_ce_pulse, err_ue_pulse;
    logic [CNT_W-1:0] ce_count, ue_count;

    ecc_rmw_datapath #(.AW(AW), .LANES(2), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .mode(mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .err_ce_pulse(err_ce_pulse), .err_ue_pulse(err_ue_pulse),
        .err_addr(err_addr), .ce_count(ce_count), .ue_count(ue_count)
    );

    // memory model with fixed read latency
    logic [MW-1:0]  mem [16];
    logic [LAT-1:0] pv;
    logic [MW-1:0]  pd [LAT];
    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        pv = '0;
        for (int i = 0; i < LAT; i++) pd[i] = '0;
    end
    always @(posedge clk) begin
        if (mem_wr_en)
            for (int j = 0; j < EW; j++)
                if (mem_wbe[j]) mem[mem_addr][j*8 +: 8] <= mem_wdata[j*8 +: 8];
        pv    <= {pv[LAT-2:0], mem_rd_en};
        pd[0] <= mem[mem_addr];
        for (int i = 1; i < LAT; i++) pd[i] <= pd[i-1];
    end
    assign mem_rvalid = pv[LAT-1];
    assign mem_rdata  = pd[LAT-1];

    int n_checks = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct { logic [DW-1:0] d; bit det; string tag; } exp_t;
    exp_t sb[$];
    int ce_seen = 0, ue_seen = 0, both_seen = 0, rd_seen = 0, wr_seen = 0;
    logic prev_ce = 1'b0, prev_ue = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (sb.size() == 0) chk(1'b0, "R6 unexpected response", rsp_rdata, '0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_rdata == e.d, e.tag, rsp_rdata, e.d);
                    chk(mem_rvalid == e.det, "R6 response timing vs mem_rvalid",
                        DW'(mem_rvalid), DW'(e.det));
                end
            end
            if (err_ce_pulse) ce_seen++;
            if (err_ue_pulse) ue_seen++;
            if (err_ce_pulse && err_ue_pulse) both_seen++;
            if ((err_ce_pulse && prev_ce) || (err_ue_pulse && prev_ue))
                chk(1'b0, "R10 pulse longer than one cycle", 1, 0);
            prev_ce = err_ce_pulse;
            prev_ue = err_ue_pulse;
            if (mem_rd_en) rd_seen++;
            if (mem_wr_en) wr_seen++;
        end
    end

    task automatic do_req(input logic wr, input int a, input logic [DW-1:0] d,
                          input logic [BW-1:0] be, input logic [1:0] md);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
        req_wdata = d; req_be = be; mode = md;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic rd(input int a, input logic [1:0] md, input logic [DW-1:0] e, input string tag);
        exp_t x;
        x.d = e; x.det = (md != 2'd2) && (md != 2'd3); x.tag = tag;
        sb.push_back(x);
        do_req(1'b0, a, '0, '0, md);
        settle();
    endtask

    task automatic wrt(input int a, input logic [DW-1:0] d, input logic [BW-1:0] be, input logic [1:0] md);
        do_req(1'b1, a, d, be, md);
        settle();
    endtask

    task automatic flip(input int a, input int b);
        mem[a][b] = ~mem[a][b];
    endtask

    function automatic logic [DW-1:0] mkd(input int n);
        return {64'hA5C3_0F1E_2D3C_4B5A ^ (64'(n) * 64'h1357_9BDF_0246_8ACF),
                64'h5A3C_F0E1_D2C3_B4A5 ^ (64'(n) * 64'h7531_FDB9_8642_0ECA)};
    endfunction

    function automatic logic [CNT_W-1:0] sat(input int n);
        return (n >= 3) ? CNT_W'(3) : CNT_W'(n);
    endfunction

    bit done = 1'b0;
    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] d, n, e;
        int rd0, wr0, ce_exp, ue_exp;
        ce_exp = 0; ue_exp = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 / R10 reset state
        chk(req_ready == 1'b1, "R9 reset ready", DW'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R10 reset rsp_valid", DW'(rsp_valid), 0);
        chk(ce_count == '0 && ue_count == '0, "R10 reset counters", DW'({ce_count, ue_count}), 0);
        chk(!err_ce_pulse && !err_ue_pulse, "R10 reset pulses", DW'({err_ce_pulse, err_ue_pulse}), 0);

        // R1 full write, clean read
        d = mkd(1); rd0 = rd_seen; wr0 = wr_seen;
        do_req(1'b1, 1, d, 16'hFFFF, 2'd2);
        chk(req_ready == 1'b1, "R9 ready after direct write", DW'(req_ready), 1);
        settle();
        chk(rd_seen == rd0 && wr_seen == wr0 + 1, "R1 direct write strobes",
            DW'({rd_seen - rd0, wr_seen - wr0}), DW'({32'd0, 32'd1}));
        rd(1, 2'd2, d, "R1 clean read data");
        chk(ce_seen == 0 && ue_seen == 0, "R1 no error on clean read", DW'(ce_seen + ue_seen), 0);

        // R2 data bit and code bit errors, corrected
        d = mkd(2);
        wrt(2, d, 16'hFFFF, 2'd2);
        flip(2, 5);
        rd(2, 2'd2, d, "R2 data bit corrected");
        ce_exp++;
        chk(ce_seen == ce_exp, "R2 ce event", DW'(ce_seen), DW'(ce_exp));
        d = mkd(3);
        wrt(3, d, 16'hFFFF, 2'd2);
        flip(3, 72 + 64 + 3);
        rd(3, 2'd2, d, "R2 code bit error leaves data");
        ce_exp++;
        chk(ce_count == sat(ce_exp), "R2 ce counter", DW'(ce_count), DW'(sat(ce_exp)));

        // R6 detect-only: flagged, not corrected
        d = mkd(4);
        wrt(4, d, 16'hFFFF, 2'd2);
        flip(4, 10);
        rd(4, 2'd1, d ^ (128'h1 << 10), "R6 detect returns raw data");
        ce_exp++;
        chk(ce_seen == ce_exp, "R6 detect flags ce", DW'(ce_seen), DW'(ce_exp));
        rd(4, 2'd2, d, "R6 correct mode repairs same word");
        ce_exp++;
        chk(ce_count == sat(ce_exp), "R10 ce counter saturates", DW'(ce_count), DW'(sat(ce_exp)));

        // R3 double error
        d = mkd(5);
        wrt(5, d, 16'hFFFF, 2'd2);
        flip(5, 0); flip(5, 1);
        rd(5, 2'd2, d ^ 128'h3, "R3 double error raw data");
        ue_exp++;
        chk(ue_seen == ue_exp && ue_count == sat(ue_exp), "R3 ue event", DW'(ue_count), DW'(sat(ue_exp)));
        chk(err_addr == AW'(5), "R3 err_addr", DW'(err_addr), 5);

        // R4 / R8 partial write with corrected single-bit error, lane1 mask 0
        d = mkd(6); n = mkd(60);
        wrt(6, d, 16'hFFFF, 2'd2);
        flip(6, 40);
        rd0 = rd_seen; wr0 = wr_seen;
        do_req(1'b1, 6, n, 16'h000F, 2'd2);
        chk(req_ready == 1'b0, "R9 stall during read-merge-write", DW'(req_ready), 0);
        settle();
        ce_exp++;
        chk(rd_seen == rd0 + 1 && wr_seen == wr0 + 1, "R4 one read then one write",
            DW'({rd_seen - rd0, wr_seen - wr0}), DW'({32'd1, 32'd1}));
        chk(ce_seen == ce_exp, "R4 ce during merge", DW'(ce_seen), DW'(ce_exp));
        e = {d[127:64], d[63:32], n[31:0]};
        rd(6, 2'd2, e, "R4 merged data with repaired byte, R8 lane1 unchanged");
        chk(ce_seen == ce_exp, "R4 re-encoded word reads clean", DW'(ce_seen), DW'(ce_exp));

        // R5 uncorrectable during merge
        d = mkd(7); n = mkd(70);
        wrt(7, d, 16'hFFFF, 2'd2);
        flip(7, 40); flip(7, 41);
        wr0 = wr_seen;
        wrt(7, n, 16'h000F, 2'd2);
        ue_exp++;
        chk(wr_seen == wr0 + 1, "R5 write completes on ue", DW'(wr_seen - wr0), 1);
        chk(ue_seen == ue_exp && err_addr == AW'(7), "R5 ue and address", DW'(err_addr), 7);
        e = {d[127:64], d[63:32] ^ 32'h300, n[31:0]};
        rd(7, 2'd2, e, "R5 merged over raw data");

        // R7 ECC off: no read phase, code byte untouched, no flags
        d = mkd(8); n = mkd(80);
        wrt(8, d, 16'hFFFF, 2'd2);
        rd0 = rd_seen;
        wrt(8, n, 16'h00F0, 2'd0);
        chk(rd_seen == rd0, "R7 off partial write has no read", DW'(rd_seen - rd0), 0);
        rd(8, 2'd0, {d[127:64], n[63:32], d[31:0]}, "R7 off partial write data");
        rd(5, 2'd0, mkd(5) ^ 128'h3, "R7 off read returns raw");
        chk(ue_seen == ue_exp && ce_seen == ce_exp, "R7 off read raises nothing",
            DW'(ue_seen), DW'(ue_exp));

        // R8 lane mask FF with other lane 00: no read phase
        d = mkd(9); n = mkd(90);
        wrt(9, d, 16'hFFFF, 2'd2);
        rd0 = rd_seen;
        wrt(9, n, 16'h00FF, 2'd2);
        chk(rd_seen == rd0, "R8 full lane mask skips read", DW'(rd_seen - rd0), 0);
        rd(9, 2'd2, {d[127:64], n[63:0]}, "R8 zero-mask lane unchanged");

        // R2 / R3 / R10: ce in lane 0 and ue in lane 1 in one response
        d = mkd(10);
        wrt(10, d, 16'hFFFF, 2'd2);
        flip(10, 3); flip(10, 73); flip(10, 74);
        rd(10, 2'd2, d ^ (128'h6 << 64), "R2 R3 mixed lanes data");
        ce_exp++; ue_exp++;
        chk(both_seen == 1, "R10 both pulses same cycle", DW'(both_seen), 1);
        chk(ce_count == sat(ce_exp) && ue_count == sat(ue_exp), "R10 counters after mixed event",
            DW'({ce_count, ue_count}), DW'({sat(ce_exp), sat(ue_exp)}));
        chk(err_addr == AW'(10), "R3 err_addr mixed", DW'(err_addr), 10);
        chk(sb.size() == 0, "R6 all responses returned", DW'(sb.size()), 0);

        done = 1'b1;
        finish_run();
    end
endmodule